// File: doc/BRIEF.md
# Video Line and Frame Timing Generator

This block derives display line and frame timing from the system clock for a 60 Hz or a 50 Hz picture. The length of one line is not a whole number of clock cycles. Each line therefore adds a fixed-point step to a phase accumulator that has 12 fractional bits. The integer part of the sum sets how many cycles the next line lasts. The fraction is kept, so the error never builds up over many lines.

On top of the line rhythm the block counts lines within a frame. It raises a blanking level and a one-cycle interrupt at a fixed line. At the frame wrap it advances a frame counter and updates an interlace field bit. The per-line tick is meant as a time base for timers elsewhere in the chip. The 50/60 Hz choice is taken at frame boundaries only, so a frame never mixes the two timings.

Top module: `vtg_top`

## Requirements
- R1: While reset is held and in the first cycle after it, lineNum, frameCnt, fieldBit, vblank and vblankIrq are all 0.
- R2: With step S per line, line n starts floor(P_n / 4096) cycles after reset release, where P_n is the sum of the steps of lines 0..n-1. The fractional remainder is carried from line to line, so after 4096 lines at one constant step S, line 4096 starts exactly at cycle S.
- R3: hsyncTick is high for exactly the first cycle of every line, including line 0 after reset, and low in every other cycle.
- R4: lineNum increments at each line start and returns to 0 after the last line of the frame. A frame has LINES_60 lines (default 263) in 60 Hz mode and LINES_50 lines (default 313) in 50 Hz mode.
- R5: vblank rises at the start of line VBLANK_LINE (default 240) and falls at the start of line 0.
- R6: vblankIrq is high for exactly one cycle, the first cycle of line VBLANK_LINE, and coincides with the rise of vblank.
- R7: frameCnt (FRAME_W bits, wrapping) increments by one at each return of lineNum to 0.
- R8: At each frame wrap, fieldBit takes the value interlaceEn AND bit 0 of the new frameCnt. Between wraps it holds.
- R9: modeSel50 (0 = 60 Hz, 1 = 50 Hz) is sampled only at the clock edge that ends the last line of a frame, and at reset. A change in mid-frame affects neither the line length nor the frame length until the next frame.
- R10: The default steps are 8791293 in 60 Hz mode and 8864320 in 50 Hz mode. The step of the selected mode is added for every line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| modeSel50 | input | 1 | 1 selects 50 Hz timing, 0 selects 60 Hz timing |
| interlaceEn | input | 1 | Enables toggling of the field bit |
| hsyncTick | output | 1 | One-cycle pulse at the start of each line |
| vblank | output | 1 | Vertical blanking level |
| vblankIrq | output | 1 | One-cycle vertical blank interrupt |
| lineNum | output | LINE_W | Current line within the frame |
| frameCnt | output | FRAME_W | Wrapping frame counter |
| fieldBit | output | 1 | Interlace field indicator |

## Verification
The bench builds the block with steps of 21709 and 25000, which give lines of about 5.3 and 6.1 cycles. Frames are 7 or 9 lines long, blanking starts at line 5, and the frame counter is 4 bits wide. These small values put every line boundary, every frame wrap, the frame counter rollover and thousands of fractional carries within a few tens of thousands of cycles. The bench compares every output in every cycle against an arithmetic model of the phase sum. It includes a 4096-line run whose end cycle is known in closed form. It also toggles the mode select every 13 cycles, so mode changes land right next to frame wraps.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  // Strobes issued by the control to the phase datapath.
  typedef struct packed {
    logic lineAdvance;  // current line ends at this edge
    logic stepSel50;    // step to add for the line that follows
  } vtgStrobe_t;

endpackage

// File: rtl/vtg_datapath.sv
module vtg_datapath
  import vtg_pkg::*;
#(
  parameter int unsigned FRAC_W  = 12,
  parameter int unsigned STEP_60 = 8791293,
  parameter int unsigned STEP_50 = 8864320,
  parameter int unsigned INT_W   = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       modeInit,
  input  vtgStrobe_t strb,
  output logic       lineLast,
  output logic       hsyncTick
);

  localparam int unsigned PHASE_W = INT_W + FRAC_W;
  localparam logic [PHASE_W-1:0] STEP60_V = PHASE_W'(STEP_60);
  localparam logic [PHASE_W-1:0] STEP50_V = PHASE_W'(STEP_50);

  logic [INT_W-1:0]   cycCnt;
  logic [INT_W-1:0]   lineLen;
  logic [FRAC_W-1:0]  phaseFrac;
  logic [PHASE_W-1:0] stepNext;
  logic [PHASE_W-1:0] phaseSum;
  logic [PHASE_W-1:0] stepInit;

  assign stepNext = strb.stepSel50 ? STEP50_V : STEP60_V;
  assign stepInit = modeInit ? STEP50_V : STEP60_V;
  assign phaseSum = {{INT_W{1'b0}}, phaseFrac} + stepNext;

  assign lineLast  = (cycCnt == lineLen - INT_W'(1));
  assign hsyncTick = (cycCnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cycCnt    <= '0;
      lineLen   <= stepInit[PHASE_W-1:FRAC_W];
      phaseFrac <= stepInit[FRAC_W-1:0];
    end else if (strb.lineAdvance) begin
      cycCnt    <= '0;
      lineLen   <= phaseSum[PHASE_W-1:FRAC_W];
      phaseFrac <= phaseSum[FRAC_W-1:0];
    end else begin
      cycCnt <= cycCnt + INT_W'(1);
    end
  end

endmodule

// File: rtl/vtg_ctrl.sv
module vtg_ctrl
  import vtg_pkg::*;
#(
  parameter int unsigned LINES_60    = 263,
  parameter int unsigned LINES_50    = 313,
  parameter int unsigned VBLANK_LINE = 240,
  parameter int unsigned LINE_W      = 9,
  parameter int unsigned FRAME_W     = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               modeSel50,
  input  logic               interlaceEn,
  input  logic               lineLast,
  output vtgStrobe_t         strb,
  output logic               vblank,
  output logic               vblankIrq,
  output logic [LINE_W-1:0]  lineNum,
  output logic [FRAME_W-1:0] frameCnt,
  output logic               fieldBit
);

  localparam logic [LINE_W-1:0] LAST60 = LINE_W'(LINES_60 - 1);
  localparam logic [LINE_W-1:0] LAST50 = LINE_W'(LINES_50 - 1);
  localparam logic [LINE_W-1:0] VBL    = LINE_W'(VBLANK_LINE);

  logic               modeReg;
  logic               frameLast;
  logic [LINE_W-1:0]  lineInc;
  logic [FRAME_W-1:0] frameInc;

  assign frameLast = (lineNum == (modeReg ? LAST50 : LAST60));
  assign lineInc   = lineNum + LINE_W'(1);
  assign frameInc  = frameCnt + FRAME_W'(1);

  always_comb begin
    strb.lineAdvance = lineLast;
    strb.stepSel50   = frameLast ? modeSel50 : modeReg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeReg   <= modeSel50;
      lineNum   <= '0;
      frameCnt  <= '0;
      fieldBit  <= 1'b0;
      vblank    <= 1'b0;
      vblankIrq <= 1'b0;
    end else begin
      vblankIrq <= 1'b0;
      if (lineLast) begin
        if (frameLast) begin
          lineNum  <= '0;
          frameCnt <= frameInc;
          fieldBit <= interlaceEn & frameInc[0];
          modeReg  <= modeSel50;
          vblank   <= 1'b0;
        end else begin
          lineNum <= lineInc;
          if (lineInc == VBL) begin
            vblank    <= 1'b1;
            vblankIrq <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
#(
  parameter int unsigned FRAC_W      = 12,
  parameter int unsigned STEP_60     = 8791293,
  parameter int unsigned STEP_50     = 8864320,
  parameter int unsigned LINES_60    = 263,
  parameter int unsigned LINES_50    = 313,
  parameter int unsigned VBLANK_LINE = 240,
  parameter int unsigned FRAME_W     = 16,
  localparam int unsigned MAX_LINES  = (LINES_60 > LINES_50) ? LINES_60 : LINES_50,
  localparam int unsigned LINE_W     = $clog2(MAX_LINES),
  localparam int unsigned MAX_STEP   = (STEP_60 > STEP_50) ? STEP_60 : STEP_50,
  localparam int unsigned INT_W      = $clog2((MAX_STEP >> FRAC_W) + 2)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               modeSel50,
  input  logic               interlaceEn,
  output logic               hsyncTick,
  output logic               vblank,
  output logic               vblankIrq,
  output logic [LINE_W-1:0]  lineNum,
  output logic [FRAME_W-1:0] frameCnt,
  output logic               fieldBit
);

  vtgStrobe_t strb;
  logic       lineLast;

  vtg_datapath #(
    .FRAC_W (FRAC_W),
    .STEP_60(STEP_60),
    .STEP_50(STEP_50),
    .INT_W  (INT_W)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .modeInit (modeSel50),
    .strb     (strb),
    .lineLast (lineLast),
    .hsyncTick(hsyncTick)
  );

  vtg_ctrl #(
    .LINES_60   (LINES_60),
    .LINES_50   (LINES_50),
    .VBLANK_LINE(VBLANK_LINE),
    .LINE_W     (LINE_W),
    .FRAME_W    (FRAME_W)
  ) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .modeSel50  (modeSel50),
    .interlaceEn(interlaceEn),
    .lineLast   (lineLast),
    .strb       (strb),
    .vblank     (vblank),
    .vblankIrq  (vblankIrq),
    .lineNum    (lineNum),
    .frameCnt   (frameCnt),
    .fieldBit   (fieldBit)
  );

endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
  parameter int unsigned LINE_W      = 9,
  parameter int unsigned FRAME_W     = 16,
  parameter int unsigned MAX_LINES   = 313,
  parameter int unsigned VBLANK_LINE = 240
) (
  input logic               clk,
  input logic               rst,
  input logic               hsyncTick,
  input logic               vblank,
  input logic               vblankIrq,
  input logic [LINE_W-1:0]  lineNum,
  input logic [FRAME_W-1:0] frameCnt,
  input logic               fieldBit
);

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    hsyncTick |=> !hsyncTick);  // R3

  AST_LINE_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !$stable(lineNum) |-> hsyncTick);  // R4

  AST_LINE_RANGE: assert property (@(posedge clk) disable iff (rst)
    lineNum < LINE_W'(MAX_LINES));  // R4

  AST_VBLANK_FALL_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $fell(vblank) |-> (lineNum == '0));  // R5

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    vblankIrq |=> !vblankIrq);  // R6

  AST_IRQ_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(vblank) |-> (vblankIrq && lineNum == LINE_W'(VBLANK_LINE)));  // R6

  AST_FRAME_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    !$stable(frameCnt) |-> (lineNum == '0 && hsyncTick));  // R7

  AST_FIELD_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    !$stable(fieldBit) |-> !$stable(frameCnt));  // R8

endmodule

bind vtg_top vtg_checker #(
  .LINE_W     (LINE_W),
  .FRAME_W    (FRAME_W),
  .MAX_LINES  (MAX_LINES),
  .VBLANK_LINE(VBLANK_LINE)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .hsyncTick(hsyncTick),
  .vblank   (vblank),
  .vblankIrq(vblankIrq),
  .lineNum  (lineNum),
  .frameCnt (frameCnt),
  .fieldBit (fieldBit)
);

// File: tb/vtg_top_tb.sv
module vtg_top_tb_top;

  localparam int S60 = 21709;
  localparam int S50 = 25000;
  localparam int L60 = 7;
  localparam int L50 = 9;
  localparam int VBL = 5;
  localparam int FW  = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       modeSel50 = 1'b0;
  logic       interlaceEn = 1'b1;
  logic       hsyncTick, vblank, vblankIrq, fieldBit;
  logic [3:0] lineNum;
  logic [3:0] frameCnt;

  int  nCmp = 0;
  int  nBad = 0;
  bit  finished = 0;

  longint pCur, pNext;
  int  t, expLine, expFrame, tickCnt;
  bit  expField, expVb, expIrq, expMode;

  always #2 clk = ~clk;

  vtg_top #(
    .STEP_60(S60), .STEP_50(S50), .LINES_60(L60), .LINES_50(L50),
    .VBLANK_LINE(VBL), .FRAME_W(FW)
  ) dut_i (
    .clk(clk), .rst(rst), .modeSel50(modeSel50), .interlaceEn(interlaceEn),
    .hsyncTick(hsyncTick), .vblank(vblank), .vblankIrq(vblankIrq),
    .lineNum(lineNum), .frameCnt(frameCnt), .fieldBit(fieldBit)
  );

  function automatic longint stepOf(bit m);
    return m ? longint'(S50) : longint'(S60);
  endfunction

  function automatic int linesOf(bit m);
    return m ? L50 : L60;
  endfunction

  task automatic cmp(string req, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s t=%0d actual=%0d expected=%0d", req, t, act, exp);
    end
  endtask

  task automatic doReset(bit m);
    rst = 1'b1;
    modeSel50 = m;
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    cmp("R1 lineNum", int'(lineNum), 0);
    cmp("R1 frameCnt", int'(frameCnt), 0);
    cmp("R1 vblank", int'(vblank), 0);
    cmp("R1 vblankIrq", int'(vblankIrq), 0);
    cmp("R1 fieldBit", int'(fieldBit), 0);
    rst = 1'b0;
    t = 0; pCur = 0; expMode = m; pNext = stepOf(m);
    expLine = 0; expFrame = 0; expField = 0; expVb = 0; expIrq = 0;
    tickCnt = 0;
    #1;
  endtask

  // toggleEvery = 0 keeps modeSel50 fixed; driftCheck checks the 4096-line point
  task automatic runCycles(int n, int toggleEvery, bit driftCheck);
    for (int i = 0; i < n; i++) begin
      cmp("R3 hsyncTick", int'(hsyncTick), int'(t == int'(pCur >> 12)));
      cmp("R4 lineNum", int'(lineNum), expLine);
      cmp("R5 vblank", int'(vblank), int'(expVb));
      cmp("R6 vblankIrq", int'(vblankIrq), int'(expIrq));
      cmp("R7 frameCnt", int'(frameCnt), expFrame);
      cmp("R8 fieldBit", int'(fieldBit), int'(expField));
      if (hsyncTick) begin
        tickCnt++;
        // R2: 4096 lines of constant step end exactly at cycle S60
        if (driftCheck && tickCnt == 4097) cmp("R2 drift", t, S60);
      end
      if (toggleEvery != 0 && (i % toggleEvery) == toggleEvery - 1)
        modeSel50 = ~modeSel50;
      // model of the edge that follows this cycle (R2, R9, R10)
      expIrq = 0;
      if (longint'(t + 1) == (pNext >> 12)) begin
        pCur = pNext;
        if (expLine == linesOf(expMode) - 1) begin
          expLine = 0;
          expFrame = (expFrame + 1) % (1 << FW);
          expField = interlaceEn & expFrame[0];
          expMode = modeSel50;
          expVb = 0;
        end else begin
          expLine++;
          if (expLine == VBL) begin
            expVb = 1;
            expIrq = 1;
          end
        end
        pNext = pCur + stepOf(expMode);
      end
      @(negedge clk);
      t++;
    end
  endtask

  initial begin
    doReset(1'b0);
    runCycles(21800, 0, 1'b1);          // R2 R10 long fixed 60 Hz run
    runCycles(7, 0, 1'b0);
    modeSel50 = 1'b1;                   // R9 mid-frame change
    runCycles(2000, 0, 1'b0);
    interlaceEn = 1'b0;                 // R8 field forced low
    runCycles(1500, 0, 1'b0);
    interlaceEn = 1'b1;
    modeSel50 = 1'b0;
    runCycles(1500, 0, 1'b0);
    runCycles(3000, 13, 1'b0);          // R9 frequent toggling
    doReset(1'b1);                      // R1 reset in 50 Hz mode
    runCycles(2000, 0, 1'b0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog t=%0d actual=running expected=done", t);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule